// File: doc/BRIEF.md
# Shared Interrupt Line Register Unit

This unit sits on an 8-bit CPU bus and collects six independent interrupt sources onto one active-low request line. The line idles high. Any source may pull it low, as on a wired-OR line. Each source keeps an enable bit and a pending flag. A one-cycle event pulse from the counter or timer that owns the source sets the pending flag. The source pulls the line low while the flag is set and the source is enabled.

Software drives every source through reads and writes at fixed bus addresses. Each source has its own way to be enabled, disabled and acknowledged. An acknowledge can be a read of a status location, any write to a register, a write to a shared status address, or a disable followed by a re-enable. The hardware does not rank the sources. The line stays low while any source is active, and software chooses the order in which it services them.

One source, the timer, is reached indirectly. A command port selects which internal register the next data-port write goes to.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all sources are disabled with nothing pending, `irqN` is high and every bit of `srcIrqN` is high.
- R2: `srcIrqN[i]` is low exactly when source i is enabled and pending, and `irqN` is the AND of all six bits. The index map is: 0 sample-done, 1 frame-step, 2 scanline, 3 extension, 4 timer, 5 disk.
- R3: Source 0 is enabled by a write to 0x4010 with data bit 7 set and disabled by any other write to 0x4010. Disabling any source clears its pending flag, which releases the line on the next clock.
- R4: A write to 0x4015 with any data acknowledges source 0.
- R5: Source 1 is enabled by a write to 0x4017 with data bits 7:6 equal to 00 and disabled by a write with any other value. A read of 0x4015 acknowledges it.
- R6: Source 2 is enabled by any write to 0xE001 and disabled by any write to 0xE000. A disable followed by a re-enable leaves it acknowledged.
- R7: Source 3 is enabled by writing 0x80 to 0x5204 and disabled by writing 0x00 there. Writing any other value there has no effect. A read of 0x5204 acknowledges it.
- R8: A write to 0x8000 stores its low 4 bits as a register select. When the select is 13, a write to 0xA000 reaches the timer (source 4):
  - writing 0x81 enables it;
  - writing any even value disables it;
  - every such write acknowledges it.
  A write to 0xA000 under any other select has no effect on source 4.
- R9: Source 5 is enabled by writing 0x02 to 0x4022 and disabled by writing 0x00 there. A read of 0x4030 acknowledges it.
- R10: An event pulse on a disabled source is ignored and leaves it not pending after it is enabled.
- R11: If an event pulse and an acknowledge of the same source fall in one cycle, the event wins and the source stays pending.
- R12: Several sources can be pending at once. Acknowledging one leaves the others active and `irqN` low until all are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | CPU bus address |
| busWrData | input | 8 | CPU bus write data |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| evtPulse | input | 6 | One-cycle event pulse per source |
| srcIrqN | output | 6 | Per-source active-low request |
| irqN | output | 1 | Combined active-low request line |

## Verification
The bench targets the corners where the sources differ, and each has its own failure mode:
- **Timer path.** An odd non-enable value written to the timer register must acknowledge it and leave it enabled. A design that treats that value as a disable would drop events that come later. A design that decodes the data port without checking the select would act on writes meant for other registers.
- **Extension source.** Stray values written to its register must change nothing.
- **Ignored events.** An event that arrives while a source is disabled must not appear once the source is re-enabled. A design that latches such events would raise a false request.
- **Event and acknowledge together.** When an acknowledge and an event land in the same cycle, a design that lets the acknowledge win would lose an interrupt.
- **Several sources pending.** With more than one source pending, the combined line must stay low until the last source is acknowledged.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NSRC   = 6;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;

  localparam int SRC_SAMPLE = 0;
  localparam int SRC_FRAME  = 1;
  localparam int SRC_LINE   = 2;
  localparam int SRC_EXT    = 3;
  localparam int SRC_TIMER  = 4;
  localparam int SRC_DISK   = 5;

  localparam logic [ADDR_W-1:0] A_SAMPLE_CTL = 16'h4010;
  localparam logic [ADDR_W-1:0] A_STATUS     = 16'h4015;
  localparam logic [ADDR_W-1:0] A_FRAME_CTL  = 16'h4017;
  localparam logic [ADDR_W-1:0] A_LINE_OFF   = 16'hE000;
  localparam logic [ADDR_W-1:0] A_LINE_ON    = 16'hE001;
  localparam logic [ADDR_W-1:0] A_EXT        = 16'h5204;
  localparam logic [ADDR_W-1:0] A_CMD        = 16'h8000;
  localparam logic [ADDR_W-1:0] A_DATA       = 16'hA000;
  localparam logic [ADDR_W-1:0] A_DISK_CTL   = 16'h4022;
  localparam logic [ADDR_W-1:0] A_DISK_STAT  = 16'h4030;
  localparam logic [SEL_W-1:0]  TIMER_SEL    = 4'd13;

  typedef struct packed {
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] dis;
    logic [NSRC-1:0] ack;
  } strobes_t;
endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          strobes
);
  logic [SEL_W-1:0] selReg;
  logic wrSample, wrStatus, wrFrame, wrLineOff, wrLineOn, wrExt, wrDisk;
  logic rdStatus, rdExt, rdDisk, wrTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selReg <= '0;
    else if (busWr && busAddr == A_CMD) selReg <= busWrData[SEL_W-1:0];
  end

  always_comb begin
    wrSample  = busWr && busAddr == A_SAMPLE_CTL;
    wrStatus  = busWr && busAddr == A_STATUS;
    wrFrame   = busWr && busAddr == A_FRAME_CTL;
    wrLineOff = busWr && busAddr == A_LINE_OFF;
    wrLineOn  = busWr && busAddr == A_LINE_ON;
    wrExt     = busWr && busAddr == A_EXT;
    wrDisk    = busWr && busAddr == A_DISK_CTL;
    wrTimer   = busWr && busAddr == A_DATA && selReg == TIMER_SEL;
    rdStatus  = busRd && busAddr == A_STATUS;
    rdExt     = busRd && busAddr == A_EXT;
    rdDisk    = busRd && busAddr == A_DISK_STAT;

    strobes = '0;
    strobes.en[SRC_SAMPLE]  = wrSample && busWrData[7];
    strobes.dis[SRC_SAMPLE] = wrSample && !busWrData[7];
    strobes.ack[SRC_SAMPLE] = wrStatus;

    strobes.en[SRC_FRAME]   = wrFrame && busWrData[7:6] == 2'b00;
    strobes.dis[SRC_FRAME]  = wrFrame && busWrData[7:6] != 2'b00;
    strobes.ack[SRC_FRAME]  = rdStatus;

    strobes.en[SRC_LINE]    = wrLineOn;
    strobes.dis[SRC_LINE]   = wrLineOff;

    strobes.en[SRC_EXT]     = wrExt && busWrData == 8'h80;
    strobes.dis[SRC_EXT]    = wrExt && busWrData == 8'h00;
    strobes.ack[SRC_EXT]    = rdExt;

    strobes.en[SRC_TIMER]   = wrTimer && busWrData == 8'h81;
    strobes.dis[SRC_TIMER]  = wrTimer && !busWrData[0];
    strobes.ack[SRC_TIMER]  = wrTimer;

    strobes.en[SRC_DISK]    = wrDisk && busWrData == 8'h02;
    strobes.dis[SRC_DISK]   = wrDisk && busWrData == 8'h00;
    strobes.ack[SRC_DISK]   = rdDisk;
  end
endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic [NSRC-1:0] evtPulse,
  output logic [NSRC-1:0] srcIrqN
);
  logic [NSRC-1:0] enReg, pendReg, enNext, pendNext;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      enNext[i] = strobes.dis[i] ? 1'b0 : (strobes.en[i] ? 1'b1 : enReg[i]);
      if (strobes.dis[i])            pendNext[i] = 1'b0;  // disable clears
      else if (evtPulse[i] && enNext[i]) pendNext[i] = 1'b1;  // event beats ack
      else if (strobes.ack[i])       pendNext[i] = 1'b0;
      else                           pendNext[i] = pendReg[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[i]   <= 1'b0;
        pendReg[i] <= 1'b0;
      end else begin
        enReg[i]   <= enNext[i];
        pendReg[i] <= pendNext[i];
      end
    end

    assign srcIrqN[i] = ~(enReg[i] & pendReg[i]);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [NSRC-1:0]   evtPulse,
  output logic [NSRC-1:0]   srcIrqN,
  output logic              irqN
);
  strobes_t strobes;

  irqagg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .strobes(strobes)
  );

  irqagg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtPulse(evtPulse),
    .srcIrqN(srcIrqN)
  );

  // wired-OR of active-low requests
  assign irqN = &srcIrqN;
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWr,
  input logic              busRd,
  input logic [NSRC-1:0]   evtPulse,
  input logic [NSRC-1:0]   srcIrqN,
  input logic              irqN
);
  p_line_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> $countones(srcIrqN) < NSRC);

  p_status_write_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == A_STATUS && !evtPulse[SRC_SAMPLE] |=> srcIrqN[SRC_SAMPLE]);

  p_status_read_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && busAddr == A_STATUS && !evtPulse[SRC_FRAME] |=> srcIrqN[SRC_FRAME]);

  p_line_disable_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == A_LINE_OFF |=> srcIrqN[SRC_LINE]);

  p_ext_read_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    busRd && !busWr && busAddr == A_EXT && !evtPulse[SRC_EXT] |=> srcIrqN[SRC_EXT]);

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    !srcIrqN[SRC_FRAME] && evtPulse[SRC_FRAME] && !busWr |=> !srcIrqN[SRC_FRAME]);
endmodule

bind irq_aggregator irqagg_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWr(busWr), .busRd(busRd), .evtPulse(evtPulse), .srcIrqN(srcIrqN),
  .irqN(irqN)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/100ps
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [5:0]  evtPulse = '0;
  logic [5:0]  srcIrqN;
  logic        irqN;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .evtPulse(evtPulse),
    .srcIrqN(srcIrqN), .irqN(irqN)
  );

  // {req[3:0], wr, rd, addr[15:0], data[7:0], evt[5:0], expSrcIrqN[5:0]}
  localparam int NV = 44;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {4'd3,  1'b1,1'b0,16'h4010,8'h80,6'h00,6'h3F}, // R3 enable sample source
    {4'd2,  1'b0,1'b0,16'h0000,8'h00,6'h01,6'h3E}, // R2 event -> bit0 low
    {4'd4,  1'b1,1'b0,16'h4015,8'h00,6'h00,6'h3F}, // R4 status write ack
    {4'd3,  1'b0,1'b0,16'h0000,8'h00,6'h01,6'h3E},
    {4'd3,  1'b1,1'b0,16'h4010,8'h00,6'h00,6'h3F}, // R3 disable clears
    {4'd10, 1'b0,1'b0,16'h0000,8'h00,6'h01,6'h3F}, // R10 ignored
    {4'd10, 1'b1,1'b0,16'h4010,8'h80,6'h00,6'h3F}, // R10 re-enable, none pending
    {4'd5,  1'b1,1'b0,16'h4017,8'h00,6'h00,6'h3F}, // R5 enable frame
    {4'd5,  1'b0,1'b0,16'h0000,8'h00,6'h02,6'h3D},
    {4'd5,  1'b0,1'b1,16'h4015,8'h00,6'h00,6'h3F}, // R5 status read ack
    {4'd5,  1'b0,1'b0,16'h0000,8'h00,6'h02,6'h3D},
    {4'd5,  1'b1,1'b0,16'h4017,8'h40,6'h00,6'h3F}, // R5 disable
    {4'd10, 1'b0,1'b0,16'h0000,8'h00,6'h02,6'h3F},
    {4'd6,  1'b1,1'b0,16'hE001,8'h12,6'h00,6'h3F}, // R6 enable
    {4'd6,  1'b0,1'b0,16'h0000,8'h00,6'h04,6'h3B},
    {4'd6,  1'b1,1'b0,16'hE000,8'h00,6'h00,6'h3F}, // R6 disable
    {4'd6,  1'b1,1'b0,16'hE001,8'h00,6'h00,6'h3F}, // R6 re-enable stays acked
    {4'd7,  1'b1,1'b0,16'h5204,8'h80,6'h00,6'h3F}, // R7 enable
    {4'd7,  1'b0,1'b0,16'h0000,8'h00,6'h08,6'h37},
    {4'd7,  1'b1,1'b0,16'h5204,8'h55,6'h00,6'h37}, // R7 other value no effect
    {4'd7,  1'b0,1'b1,16'h5204,8'h00,6'h00,6'h3F}, // R7 read ack
    {4'd7,  1'b0,1'b0,16'h0000,8'h00,6'h08,6'h37},
    {4'd7,  1'b1,1'b0,16'h5204,8'h00,6'h00,6'h3F}, // R7 disable
    {4'd8,  1'b1,1'b0,16'h8000,8'h0D,6'h00,6'h3F}, // R8 select 13
    {4'd8,  1'b1,1'b0,16'hA000,8'h81,6'h00,6'h3F}, // R8 enable
    {4'd8,  1'b0,1'b0,16'h0000,8'h00,6'h10,6'h2F},
    {4'd8,  1'b1,1'b0,16'hA000,8'h33,6'h00,6'h3F}, // R8 odd write acks only
    {4'd8,  1'b0,1'b0,16'h0000,8'h00,6'h10,6'h2F}, // R8 still enabled
    {4'd8,  1'b1,1'b0,16'h8000,8'h0C,6'h00,6'h2F},
    {4'd8,  1'b1,1'b0,16'hA000,8'h44,6'h00,6'h2F}, // R8 other select no effect
    {4'd8,  1'b1,1'b0,16'h8000,8'h0D,6'h00,6'h2F},
    {4'd8,  1'b1,1'b0,16'hA000,8'h44,6'h00,6'h3F}, // R8 even disables
    {4'd10, 1'b0,1'b0,16'h0000,8'h00,6'h10,6'h3F},
    {4'd9,  1'b1,1'b0,16'h4022,8'h02,6'h00,6'h3F}, // R9 enable
    {4'd9,  1'b0,1'b0,16'h0000,8'h00,6'h20,6'h1F},
    {4'd9,  1'b0,1'b1,16'h4030,8'h00,6'h00,6'h3F}, // R9 read ack
    {4'd9,  1'b0,1'b0,16'h0000,8'h00,6'h20,6'h1F},
    {4'd9,  1'b1,1'b0,16'h4022,8'h00,6'h00,6'h3F}, // R9 disable
    {4'd12, 1'b0,1'b0,16'h0000,8'h00,6'h05,6'h3A}, // R12 two pending
    {4'd12, 1'b1,1'b0,16'h4015,8'h00,6'h00,6'h3B}, // R12 one acked, line low
    {4'd12, 1'b1,1'b0,16'hE000,8'h00,6'h00,6'h3F}, // R12 all clear
    {4'd11, 1'b0,1'b0,16'h0000,8'h00,6'h01,6'h3E},
    {4'd11, 1'b1,1'b0,16'h4015,8'h00,6'h01,6'h3E}, // R11 event beats ack
    {4'd11, 1'b1,1'b0,16'h4015,8'h00,6'h00,6'h3F}
  };

  task automatic check(input int req, input logic [5:0] expSrc, input string what);
    checks++;
    if (srcIrqN !== expSrc || irqN !== (&expSrc)) begin
      fails++;
      $display("FAIL R%0d %s: srcIrqN=%h irqN=%b expected srcIrqN=%h irqN=%b",
               req, what, srcIrqN, irqN, expSrc, &expSrc);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                      input logic [7:0] d, input logic [5:0] e);
    busWr = wr; busRd = rd; busAddr = a; busWrData = d; evtPulse = e;
    @(posedge clk); #1;
    busWr = 1'b0; busRd = 1'b0; evtPulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, 6'h3F, "during reset"); // R1
    rstN = 1'b1;
    @(posedge clk); #1;
    check(1, 6'h3F, "after reset"); // R1
    step(1'b0, 1'b0, 16'h0000, 8'h00, 6'h3F);
    check(10, 6'h3F, "events before any enable"); // R10

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      step(v[37], v[36], v[35:20], v[19:12], v[11:6]);
      check(int'(v[41:38]), v[5:0], $sformatf("vector %0d", i));
    end

    // R1: reset in the middle of an active request
    step(1'b1, 1'b0, 16'hE001, 8'h00, 6'h00);
    step(1'b0, 1'b0, 16'h0000, 8'h00, 6'h04);
    check(2, 6'h3B, "scanline pending before reset");
    rstN = 1'b0; #1;
    check(1, 6'h3F, "async reset releases line");
    @(posedge clk); #1;
    rstN = 1'b1;
    step(1'b0, 1'b0, 16'h0000, 8'h00, 6'h3F);
    check(1, 6'h3F, "enables cleared by reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule